// File: doc/BRIEF.md
# Packet Field Load Unit

This unit serves the packet reads of a filter sequencer. A request names an access mode, a size and an immediate offset k, and carries the current index register value. The unit reads the packet buffer one byte per cycle, starting at the requested offset, and puts the bytes together most significant first. It returns the result, zero-extended to 32 bits, through a valid/ready response channel. A request needs no alignment: a halfword or word may start at any byte.

Before the buffer is touched, the unit checks every access against the captured length. An access that would reach any byte at or past that length returns a fault and no data. Two further modes need little or no buffer traffic. The header-length mode reads one byte and returns four times its low nibble. The length mode returns the wire length and does not read the buffer at all. Only one request is in flight at a time: the request side is ready only while no result is pending.

Top module: `pkt_field_ld`

## Requirements
- R1: In absolute mode (mode code 0) the offset is k. Offset 0 is the first packet byte, and a load of any size may start at any byte offset.
- R2: In indexed mode (mode code 1) the offset is index + k, formed without wraparound. An index of 0xFFFFFFFF with k = 2 is therefore out of bounds and faults.
- R3: Size code 0 loads a byte, code 1 a halfword, and codes 2 and 3 a word. The first byte read becomes the most significant byte. Every result bit above the loaded bytes is zero.
- R4: In header-length mode (mode code 2) the unit reads exactly one byte at offset k and returns 4 × (byte & 0xF), so only bits 5:2 can be set. The index and size inputs have no effect in this mode.
- R5: When offset + size exceeds the captured length, the unit returns fault = 1 and data = 0, and it issues no buffer read.
- R6: In length mode (mode code 3) the unit returns the wire length with fault = 0, even when the wire length is larger than the captured length. It issues no buffer read.
- R7: req_ready_o is high only when no result is pending. A response, once valid, holds its data and fault unchanged until rsp_ready_i is high.
- R8: After reset, req_ready_o is high, and rsp_valid_o and buf_rd_en_o are low.
- R9: A successful load issues exactly as many one-byte buffer reads as its size, at ascending addresses starting at the offset. The buffer returns each byte in the cycle after its read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_mode_i | input | 2 | 0 absolute, 1 indexed, 2 header length, 3 wire length |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_k_i | input | 32 | Immediate offset k |
| req_x_i | input | 32 | Index register value |
| cap_len_i | input | 32 | Captured length in bytes, sampled at accept |
| wire_len_i | input | 32 | Wire length, sampled at accept |
| buf_rd_en_o | output | 1 | Buffer byte read strobe |
| buf_addr_o | output | BUF_AW | Buffer byte address |
| buf_data_i | input | 8 | Buffer byte, valid the cycle after the strobe |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_data_o | output | 32 | Loaded value |
| rsp_fault_o | output | 1 | Access ran past the captured length |

## Verification
Several properties are checked by assertions on every cycle. A pending response holds steady, and no request is accepted while one is pending. A fault always carries zero data, and every buffer read lies below the captured length. Reads step upward one address at a time, and their count matches the load size. Byte, halfword and header-length results have the correct shape, and length reads never fault. The bench scenarios are needed for the rest: the actual byte values and their order, the index-plus-k wrap case, the exact boundary either side of the captured length, and the fact that the index and size inputs are ignored in header-length mode.

// File: rtl/pkt_ld_pkg.sv
package pkt_ld_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 3;

  typedef enum logic [1:0] {
    LD_ABS = 2'd0,
    LD_IDX = 2'd1,
    LD_HDR = 2'd2,
    LD_LEN = 2'd3
  } ld_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } ld_size_e;

  function automatic logic [CNT_W-1:0] span_bytes(ld_mode_e m, ld_size_e s);
    if (m == LD_LEN) return '0;
    if (m == LD_HDR) return CNT_W'(1);
    case (s)
      SZ_BYTE: return CNT_W'(1);
      SZ_HALF: return CNT_W'(2);
      default: return CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/pkt_ld_span.sv
module pkt_ld_span
  import pkt_ld_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [WORD_W-1:0] k_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] cap_len_i,
  output logic [WORD_W:0]   off_o,
  output logic [CNT_W-1:0]  nbytes_o,
  output logic              fault_o
);
  localparam int unsigned END_W = WORD_W + 2;

  ld_mode_e         mode;
  logic [END_W-1:0] end_w;

  always_comb begin
    mode     = ld_mode_e'(mode_i);
    // 33-bit sum: index + k can never wrap back into bounds
    off_o    = (mode == LD_IDX) ? ({1'b0, x_i} + {1'b0, k_i}) : {1'b0, k_i};
    nbytes_o = span_bytes(mode, ld_size_e'(size_i));
    end_w    = {1'b0, off_o} + {{(END_W-CNT_W){1'b0}}, nbytes_o};
    fault_o  = (mode != LD_LEN) && (end_w > {2'b00, cap_len_i});
  end
endmodule

// File: rtl/pkt_ld_fetch.sv
module pkt_ld_fetch
  import pkt_ld_pkg::*;
#(
  parameter int unsigned BUF_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [BUF_AW-1:0] off_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  output logic              buf_rd_en_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned ACC_W = WORD_W - 8;

  logic [BUF_AW-1:0] iss_addr_q;
  logic [CNT_W-1:0]  iss_left_q;
  logic [CNT_W-1:0]  rcv_left_q;
  logic              pend_q;
  logic [ACC_W-1:0]  acc_q;

  assign buf_rd_en_o = (iss_left_q != '0);
  assign buf_addr_o  = iss_addr_q;
  assign done_o      = pend_q && (rcv_left_q == CNT_W'(1));
  assign word_o      = {acc_q, buf_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_addr_q <= '0;
      iss_left_q <= '0;
      rcv_left_q <= '0;
      pend_q     <= 1'b0;
      acc_q      <= '0;
    end else begin
      pend_q <= buf_rd_en_o;
      if (go_i) begin
        iss_addr_q <= off_i;
        iss_left_q <= nbytes_i;
        rcv_left_q <= nbytes_i;
        acc_q      <= '0;
      end else begin
        if (buf_rd_en_o) begin
          iss_addr_q <= iss_addr_q + BUF_AW'(1);
          iss_left_q <= iss_left_q - CNT_W'(1);
        end
        if (pend_q) begin
          // big-endian: earlier bytes shift toward the top
          acc_q      <= {acc_q[ACC_W-9:0], buf_data_i};
          rcv_left_q <= rcv_left_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pkt_ld_rsp.sv
module pkt_ld_rsp
  import pkt_ld_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              fault_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      fault_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      fault_o <= fault_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_field_ld.sv
module pkt_field_ld
  import pkt_ld_pkg::*;
#(
  parameter int unsigned BUF_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_mode_i,
  input  logic [1:0]        req_size_i,
  input  logic [31:0]       req_k_i,
  input  logic [31:0]       req_x_i,
  input  logic [31:0]       cap_len_i,
  input  logic [31:0]       wire_len_i,
  output logic              buf_rd_en_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_data_o,
  output logic              rsp_fault_o
);
  localparam int unsigned HDR_PAD = WORD_W - 6;

  logic              busy_q;
  ld_mode_e          mode_q;
  logic              accept, quick, go;
  logic [WORD_W:0]   span_off;
  logic [CNT_W-1:0]  span_n;
  logic              span_fault;
  logic              fetch_done;
  logic [WORD_W-1:0] fetch_word;
  logic              rsp_load;
  logic [WORD_W-1:0] rsp_din;
  logic              rsp_fin;

  assign req_ready_o = !busy_q;
  assign accept      = req_valid_i && !busy_q;
  assign quick       = accept && (span_fault || (ld_mode_e'(req_mode_i) == LD_LEN));
  assign go          = accept && !quick;

  pkt_ld_span u_span (
    .mode_i    (req_mode_i),
    .size_i    (req_size_i),
    .k_i       (req_k_i),
    .x_i       (req_x_i),
    .cap_len_i (cap_len_i),
    .off_o     (span_off),
    .nbytes_o  (span_n),
    .fault_o   (span_fault)
  );

  pkt_ld_fetch #(.BUF_AW(BUF_AW)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .off_i       (span_off[BUF_AW-1:0]),
    .nbytes_i    (span_n),
    .buf_rd_en_o (buf_rd_en_o),
    .buf_addr_o  (buf_addr_o),
    .buf_data_i  (buf_data_i),
    .done_o      (fetch_done),
    .word_o      (fetch_word)
  );

  always_comb begin
    rsp_load = quick || fetch_done;
    rsp_fin  = quick && span_fault;
    if (quick)
      rsp_din = span_fault ? '0 : wire_len_i;
    else if (mode_q == LD_HDR)
      rsp_din = {{HDR_PAD{1'b0}}, fetch_word[3:0], 2'b00};
    else
      rsp_din = fetch_word;
  end

  pkt_ld_rsp u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rsp_load),
    .data_i  (rsp_din),
    .fault_i (rsp_fin),
    .ready_i (rsp_ready_i),
    .valid_o (rsp_valid_o),
    .data_o  (rsp_data_o),
    .fault_o (rsp_fault_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= LD_ABS;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= ld_mode_e'(req_mode_i);
      end else if (rsp_valid_o && rsp_ready_i) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_field_ld_chk.sv
module pkt_field_ld_chk #(
  parameter int unsigned BUF_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_mode_i,
  input logic [1:0]        req_size_i,
  input logic [31:0]       cap_len_i,
  input logic [31:0]       wire_len_i,
  input logic              buf_rd_en_o,
  input logic [BUF_AW-1:0] buf_addr_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [31:0]       rsp_data_o,
  input logic              rsp_fault_o
);
  logic [1:0]  mode_q, size_q;
  logic [31:0] cap_q, wlen_q;
  logic [2:0]  rd_cnt_q;
  logic [2:0]  exp_n;
  logic        acc;

  assign acc   = req_valid_i && req_ready_o;
  assign exp_n = (mode_q == 2'd2) ? 3'd1 : (size_q == 2'd0) ? 3'd1 :
                 (size_q == 2'd1) ? 3'd2 : 3'd4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      size_q   <= '0;
      cap_q    <= '0;
      wlen_q   <= '0;
      rd_cnt_q <= '0;
    end else if (acc) begin
      mode_q   <= req_mode_i;
      size_q   <= req_size_i;
      cap_q    <= cap_len_i;
      wlen_q   <= wire_len_i;
      rd_cnt_q <= '0;
    end else if (buf_rd_en_o) begin
      rd_cnt_q <= rd_cnt_q + 3'd1;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_fault_o)); // R7
  AST_ONE_INFLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R7
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_data_o == 32'd0); // R5
  AST_RD_IN_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_en_o |-> {{(32-BUF_AW){1'b0}}, buf_addr_o} < cap_q); // R5
  AST_NO_RD_QUICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) && (rsp_fault_o || mode_q == 2'd3) |-> rd_cnt_q == 3'd0); // R5
  AST_RD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) && !rsp_fault_o && mode_q != 2'd3 |-> rd_cnt_q == exp_n); // R9
  AST_RD_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_en_o && $past(buf_rd_en_o) |-> buf_addr_o == $past(buf_addr_o) + BUF_AW'(1)); // R9
  AST_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && mode_q[1] == 1'b0 && size_q == 2'd0 |-> rsp_data_o[31:8] == 24'd0); // R3
  AST_HALF_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && mode_q[1] == 1'b0 && size_q == 2'd1 |-> rsp_data_o[31:16] == 16'd0); // R3
  AST_HDR_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && mode_q == 2'd2 |-> rsp_data_o[31:6] == 26'd0 && rsp_data_o[1:0] == 2'd0); // R4
  AST_LEN_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && mode_q == 2'd3 |-> !rsp_fault_o && rsp_data_o == wlen_q); // R6
endmodule

bind pkt_field_ld pkt_field_ld_chk #(.BUF_AW(BUF_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_mode_i  (req_mode_i),
  .req_size_i  (req_size_i),
  .cap_len_i   (cap_len_i),
  .wire_len_i  (wire_len_i),
  .buf_rd_en_o (buf_rd_en_o),
  .buf_addr_o  (buf_addr_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_data_o  (rsp_data_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/pkt_field_ld_tb.sv
module pkt_field_ld_tb;
  localparam int BUF_AW = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [1:0]        req_mode_i = '0;
  logic [1:0]        req_size_i = '0;
  logic [31:0]       req_k_i = '0;
  logic [31:0]       req_x_i = '0;
  logic [31:0]       cap_len_i = '0;
  logic [31:0]       wire_len_i = '0;
  logic              buf_rd_en_o;
  logic [BUF_AW-1:0] buf_addr_o;
  logic [7:0]        buf_data_i = '0;
  logic              rsp_valid_o;
  logic              rsp_ready_i = 1'b0;
  logic [31:0]       rsp_data_o;
  logic              rsp_fault_o;

  always #2 clk_i = ~clk_i;

  pkt_field_ld #(.BUF_AW(BUF_AW)) u_dut (.*);

  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'((i * 29 + 7) & 255);
  always @(posedge clk_i) if (buf_rd_en_o) buf_data_i <= mem[buf_addr_o];

  typedef struct {
    logic [31:0] data;
    logic        fault;
    int          nrd;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0, rd_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] m, input logic [1:0] s, input logic [31:0] k,
                                 input logic [31:0] x, input logic [31:0] cap, input logic [31:0] wl);
    exp_t e;
    logic [33:0] off, fin;
    int n;
    n   = (m == 2'd3) ? 0 : (m == 2'd2) ? 1 : (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    off = (m == 2'd1) ? ({2'b00, x} + {2'b00, k}) : {2'b00, k};
    fin = off + 34'(n);
    e.fault = (m != 2'd3) && (fin > {2'b00, cap});
    e.data  = '0;
    if (m == 2'd3) e.data = wl;
    else if (!e.fault) begin
      for (int i = 0; i < n; i++) e.data = (e.data << 8) | {24'd0, mem[8'(off[7:0] + 8'(i))]};
      if (m == 2'd2) e.data = {26'd0, e.data[3:0], 2'b00};
    end
    e.nrd = e.fault ? 0 : n;
    return e;
  endfunction

  task automatic send(input string tag, input logic [1:0] m, input logic [1:0] s, input logic [31:0] k,
                      input logic [31:0] x, input logic [31:0] cap, input logic [31:0] wl);
    exp_t e;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_mode_i = m; req_size_i = s; req_k_i = k; req_x_i = x;
    cap_len_i = cap; wire_len_i = wl; req_valid_i = 1'b1;
    e = model(m, s, k, x, cap, wl);
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    int cyc = 0;
    logic        stall = 0;
    logic [31:0] held_d = '0;
    logic        held_f = 0;
    exp_t e;
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      cyc++;
      if (stall) begin
        chk(rsp_valid_o && rsp_data_o == held_d && rsp_fault_o == held_f, "R7 hold",
            rsp_data_o, held_d);
      end
      rsp_ready_i = (cyc % 3) != 1;
      if (buf_rd_en_o) rd_seen++;
      stall  = rsp_valid_o && !rsp_ready_i;
      held_d = rsp_data_o;
      held_f = rsp_fault_o;
      if (rsp_valid_o && rsp_ready_i) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected response", rsp_data_o, 0);
        else begin
          e = exp_q.pop_front();
          chk(rsp_data_o == e.data, {e.tag, " data"}, rsp_data_o, e.data);
          chk(rsp_fault_o == e.fault, {e.tag, " fault"}, 32'(rsp_fault_o), 32'(e.fault));
          chk(rd_seen == e.nrd, {e.tag, " R9 read count"}, 32'(rd_seen), 32'(e.nrd));
        end
        rd_seen = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R8 ready", 32'(req_ready_o), 1);
    chk(rsp_valid_o == 1'b0, "R8 rsp_valid", 32'(rsp_valid_o), 0);
    chk(buf_rd_en_o == 1'b0, "R8 rd_en", 32'(buf_rd_en_o), 0);

    send("R1 abs byte k0",      2'd0, 2'd0, 32'd0,  32'd0, 32'd40, 32'd1500);
    send("R1 abs word k3",      2'd0, 2'd2, 32'd3,  32'd9, 32'd40, 32'd1500);
    send("R3 abs half k5",      2'd0, 2'd1, 32'd5,  32'd0, 32'd40, 32'd1500);
    send("R3 size3 word k17",   2'd0, 2'd3, 32'd17, 32'd0, 32'd40, 32'd1500);
    send("R2 idx word x10 k7",  2'd1, 2'd2, 32'd7,  32'd10, 32'd40, 32'd1500);
    send("R2 idx half x1 k0",   2'd1, 2'd1, 32'd0,  32'd1, 32'd40, 32'd1500);
    send("R2 idx wrap",         2'd1, 2'd0, 32'd2,  32'hFFFF_FFFF, 32'd40, 32'd1500);
    send("R5 word end ok",      2'd0, 2'd2, 32'd36, 32'd0, 32'd40, 32'd1500);
    send("R5 word end fault",   2'd0, 2'd2, 32'd37, 32'd0, 32'd40, 32'd1500);
    send("R5 byte last ok",     2'd0, 2'd0, 32'd39, 32'd0, 32'd40, 32'd1500);
    send("R5 byte at cap",      2'd0, 2'd0, 32'd40, 32'd0, 32'd40, 32'd1500);
    send("R5 huge k",           2'd0, 2'd1, 32'hFFFF_FFFF, 32'd0, 32'd40, 32'd1500);
    send("R4 hdr k12",          2'd2, 2'd0, 32'd12, 32'd0, 32'd40, 32'd1500);
    send("R4 hdr x/size ignored", 2'd2, 2'd2, 32'd12, 32'd5, 32'd40, 32'd1500);
    send("R4 hdr k at cap",     2'd2, 2'd0, 32'd40, 32'd0, 32'd40, 32'd1500);
    send("R6 wire len",         2'd3, 2'd2, 32'hFFFF_0000, 32'd3, 32'd40, 32'd1500);
    send("R6 cap zero",         2'd3, 2'd0, 32'd0,  32'd0, 32'd0, 32'd64);
    send("R5 cap zero load",    2'd0, 2'd0, 32'd0,  32'd0, 32'd0, 32'd64);
    send("R1 abs word k250",    2'd0, 2'd2, 32'd250, 32'd0, 32'd255, 32'd300);

    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R7 idle after drain", 32'(req_ready_o), 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule